// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block turns one copy request into a stream of memory write commands aimed at a ring buffer. A request names a source address, the current write index inside the ring, the ring's base and length, and a byte count. The block then issues one command per cycle. Each command carries a destination address, a matching source address and an access width. The width is the largest of 8, 4, 2 or 1 bytes that suits the alignment of both addresses and the bytes still to move, and that stays inside the ring.

The index moves forward by each access width. When it lands on the ring's end it folds back to the base, computed as old index plus step minus length. The fold is applied before the next command goes out, so a wide access can never run past the end of the ring. An access that would cross the end is narrowed, and the rest of the transfer continues from the base. A one-cycle pulse marks the end of a transfer. A malformed request raises an error pulse and issues no commands.

Top module: `circ_addr_gen`

## Requirements
- R1: An 8-byte access (cmd_size_o = 3) is issued when source and destination are both 8-byte aligned, at least 8 bytes remain, and at least 8 bytes lie between the destination and the ring end.
- R2: Failing R1, the widest of 4 bytes (size 2), 2 bytes (size 1) or 1 byte (size 0) is chosen under the same three conditions at that width; a single byte is always allowed.
- R3: No command touches a byte outside [base, base+length): a width that would cross the ring end is narrowed to the next smaller width.
- R4: After each accepted command the index advances by the access width; reaching base+length it returns to base (index + width − length), and the next command already uses the folded address.
- R5: A command stays valid with unchanged address and size while cmd_ready_i is low; exactly one command completes per cycle in which cmd_valid_o and cmd_ready_i are both high.
- R6: done_o pulses for one cycle, the cycle after the last command is accepted, and idx_o then holds the updated index.
- R7: A request with length zero, or a byte count above the length, pulses err_o in the next cycle and issues no command.
- R8: A request with a byte count of zero pulses done_o in the next cycle and issues no command.
- R9: After reset cmd_valid_o, done_o, err_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken while busy_o is low |
| src_i | input | AW | Source start address |
| idx_i | input | AW | Current write index inside the ring |
| base_i | input | AW | Ring base address |
| len_i | input | CW | Ring length in bytes |
| count_i | input | CW | Bytes to move |
| cmd_valid_o | output | 1 | Command available |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_addr_o | output | AW | Destination address of the command |
| cmd_src_o | output | AW | Source address of the command |
| cmd_size_o | output | 2 | log2 of access width in bytes |
| idx_o | output | AW | Updated write index |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished pulse |
| err_o | output | 1 | Request rejected pulse |

## Verification
The sharpest case is a ring of 8 bytes based at 0x02 fed writes of 2, 4 and 4 bytes: a design that checks only alignment writes 4 bytes at 0x08 and spills onto 0x0A–0x0B, while a design that folds the index late issues the tail at the wrong address. Other cases cover a ring end that leaves room for a single byte, source and destination of mismatched alignment that force narrow beats, and a transfer that ends exactly on the ring end. Stalls on cmd_ready_i check that a command and the index do not drift while waiting, and bad or empty requests check that nothing is issued.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_e;
  localparam int unsigned MAX_LOG = 3;
endpackage

// File: rtl/cbag_size_pick.sv
module cbag_size_pick
  import cbag_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] rem_i,
  input  logic [AW-1:0] room_i,
  output size_e         size_o
);
  // ascending scan: the last width that fits is the widest
  always_comb begin
    size_o = SZ_B1;
    for (int k = 1; k <= int'(MAX_LOG); k++) begin
      if ((((src_i | dst_i) & AW'((32'd1 << k) - 32'd1)) == '0) &&
          (rem_i >= CW'(32'd1 << k)) &&
          (room_i >= AW'(32'd1 << k)))
        size_o = size_e'(k);
    end
  end
endmodule

// File: rtl/cbag_wrap.sv
module cbag_wrap #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] len_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] sum;
  assign sum   = dst_i + step_i;
  assign nxt_o = (sum >= end_i) ? sum - AW'(len_i) : sum;
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cbag_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] count_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [AW-1:0] cmd_addr_o,
  output logic [AW-1:0] cmd_src_o,
  output logic [1:0]    cmd_size_o,
  output logic [AW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  logic          busy_q, done_q, err_q;
  logic [AW-1:0] src_q, dst_q, base_q, end_q;
  logic [CW-1:0] len_q, rem_q;
  logic [AW-1:0] room, step, dst_nxt;
  size_e         size;
  logic          fire, bad_req;

  assign room    = end_q - dst_q;
  assign step    = AW'(1) << size;
  assign fire    = busy_q & cmd_ready_i;
  assign bad_req = (len_i == '0) || (count_i > len_i);

  cbag_size_pick #(.AW(AW), .CW(CW)) u_pick (
    .src_i (src_q),
    .dst_i (dst_q),
    .rem_i (rem_q),
    .room_i(room),
    .size_o(size)
  );

  cbag_wrap #(.AW(AW), .CW(CW)) u_wrap (
    .dst_i (dst_q),
    .step_i(step),
    .end_i (end_q),
    .len_i (len_q),
    .nxt_o (dst_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      base_q <= '0;
      end_q  <= '0;
      len_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (bad_req) begin
            err_q <= 1'b1;
          end else if (count_i == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            src_q  <= src_i;
            dst_q  <= idx_i;
            base_q <= base_i;
            end_q  <= base_i + AW'(len_i);
            len_q  <= len_i;
            rem_q  <= count_i;
          end
        end
      end else if (fire) begin
        src_q <= src_q + step;
        dst_q <= dst_nxt;
        rem_q <= rem_q - CW'(step);
        if (rem_q == CW'(step)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_valid_o = busy_q;
  assign cmd_addr_o  = dst_q;
  assign cmd_src_o   = src_q;
  assign cmd_size_o  = size;
  assign idx_o       = dst_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/cbag_checker.sv
module cbag_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_i,
  input logic [AW-1:0] cmd_addr_i,
  input logic [1:0]    cmd_size_i,
  input logic [AW-1:0] ring_base_i,
  input logic [AW-1:0] ring_end_i,
  input logic          done_i,
  input logic          err_i
);
  logic [AW-1:0] nbytes;
  assign nbytes = AW'(1) << cmd_size_i;

  p_in_ring_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> (cmd_addr_i >= ring_base_i) && (cmd_addr_i + nbytes <= ring_end_i));

  p_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> ((cmd_addr_i & (nbytes - AW'(1))) == '0));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_ready_i) |=> (cmd_valid_i && $stable(cmd_addr_i) && $stable(cmd_size_i)));

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (!cmd_valid_i && !done_i));

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !cmd_valid_i);
endmodule

bind circ_addr_gen cbag_checker #(.AW(AW)) u_cbag_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_addr_i (cmd_addr_o),
  .cmd_size_i (cmd_size_o),
  .ring_base_i(base_q),
  .ring_end_i (end_q),
  .done_i     (done_o),
  .err_i      (err_o)
);

// File: tb/circ_addr_gen_tb_top.sv
module circ_addr_gen_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src = '0, idx = '0, base = '0;
  logic [CW-1:0] len = '0, cnt = '0;
  logic          cmd_ready = 1'b1;
  logic          cmd_valid, busy, done, err;
  logic [AW-1:0] cmd_addr, cmd_src, idx_out;
  logic [1:0]    cmd_size;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  circ_addr_gen #(.AW(AW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_i(src), .idx_i(idx), .base_i(base), .len_i(len), .count_i(cnt),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .cmd_src_o(cmd_src), .cmd_size_o(cmd_size),
    .idx_o(idx_out), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // base, len, dst, src, count, beats, final idx, then (addr,size) x4
  localparam int NV = 9;
  localparam int TBL [NV][15] = '{
    '{'h40, 64, 'h40, 'h200, 16, 2, 'h50, 'h40, 3, 'h48, 3, 0, 0, 0, 0},
    '{'h40, 64, 'h41, 'h301,  7, 3, 'h48, 'h41, 0, 'h42, 1, 'h44, 2, 0, 0},
    '{'h40, 64, 'h40, 'h202,  8, 4, 'h48, 'h40, 1, 'h42, 1, 'h44, 1, 'h46, 1},
    '{'h40, 16, 'h48, 'h400, 12, 2, 'h44, 'h48, 3, 'h40, 2, 0, 0, 0, 0},
    '{'h02,  8, 'h02, 'h100,  2, 1, 'h04, 'h02, 1, 0, 0, 0, 0, 0, 0},
    '{'h02,  8, 'h04, 'h104,  4, 1, 'h08, 'h04, 2, 0, 0, 0, 0, 0, 0},
    '{'h02,  8, 'h08, 'h108,  4, 2, 'h04, 'h08, 1, 'h02, 1, 0, 0, 0, 0},
    '{'h10,  8, 'h14, 'h004,  8, 2, 'h14, 'h14, 2, 'h10, 2, 0, 0, 0, 0},
    '{'h20,  5, 'h24, 'h000,  3, 3, 'h22, 'h24, 0, 'h20, 0, 'h21, 0, 0, 0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input int b, input int l, input int d, input int s, input int c);
    @(negedge clk);
    base = AW'(b); len = CW'(l); idx = AW'(d); src = AW'(s); cnt = CW'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // collect beats until done, comparing with table row r
  task automatic collect(input int r, input string req);
    int nb = 0;
    for (int c = 0; c < 40; c++) begin
      if (done) break;
      if (cmd_valid && cmd_ready) begin
        if (nb < 4) begin
          chk(int'(cmd_addr) == TBL[r][7+2*nb], req, "beat addr", int'(cmd_addr), TBL[r][7+2*nb]);
          chk(int'(cmd_size) == TBL[r][8+2*nb], req, "beat size", int'(cmd_size), TBL[r][8+2*nb]);
        end
        nb++;
      end
      @(negedge clk);
    end
    chk(done == 1'b1, "R6", "done pulse", int'(done), 1);
    chk(nb == TBL[r][5], req, "beat count", nb, TBL[r][5]);
    chk(int'(idx_out) == TBL[r][6], "R4", "final index", int'(idx_out), TBL[r][6]);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", int'(done), 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!cmd_valid && !done && !err && !busy, "R9", "reset outputs",
        int'({cmd_valid, done, err, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 wide beats, R2 fallbacks, R3/R4 ring end and fold
    for (int r = 0; r < NV; r++) begin
      do_start(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4]);
      collect(r, (r == 0) ? "R1" : (r < 3) ? "R2" : "R3");
    end

    // R5 stall: ready low holds first command of row 3
    cmd_ready = 1'b0;
    do_start(TBL[3][0], TBL[3][1], TBL[3][2], TBL[3][3], TBL[3][4]);
    for (int c = 0; c < 3; c++) begin
      chk(cmd_valid && cmd_addr == 32'h48 && cmd_size == 2'd3, "R5", "held command",
          int'(cmd_addr), 'h48);
      chk(idx_out == 32'h48, "R5", "index during stall", int'(idx_out), 'h48);
      @(negedge clk);
    end
    cmd_ready = 1'b1;
    collect(3, "R5");

    // R7 length zero
    do_start('h40, 0, 'h40, 'h0, 0);
    chk(err && !cmd_valid, "R7", "zero length error", int'({err, cmd_valid}), 2);
    @(negedge clk);
    chk(!err && !cmd_valid && !busy, "R7", "no command after error",
        int'({err, cmd_valid, busy}), 0);

    // R7 count above length
    do_start('h40, 8, 'h40, 'h0, 9);
    chk(err && !cmd_valid, "R7", "oversize error", int'({err, cmd_valid}), 2);
    @(negedge clk);
    chk(!cmd_valid && !done, "R7", "oversize quiet", int'({cmd_valid, done}), 0);

    // R8 empty transfer
    do_start('h40, 8, 'h44, 'h0, 0);
    chk(done && !cmd_valid && !err, "R8", "empty done", int'({done, cmd_valid, err}), 4);
    @(negedge clk);
    chk(!done && !cmd_valid, "R8", "empty quiet", int'({done, cmd_valid}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule